// File: doc/BRIEF.md
# 16-bit ALU with Status Flags

This block is a 16-bit arithmetic and logic unit with a 16-bit status register. Each operation takes two 16-bit operands and a 3-bit operation code. The result is purely combinational. The condition flags are captured into the status register on the rising clock edge, but only when the flag write enable is high. Add-with-carry and subtract-with-borrow take their carry input from the stored carry flag, so multi-word arithmetic can be chained one 16-bit slice per cycle.

Three machine-control flags (direction, interrupt and trap) live in the upper byte of the status register. They change only through dedicated per-bit set and clear inputs, and they are never touched by arithmetic. What those flags cause elsewhere in a processor is outside this block.

Top module: `alu16_flags`

## Requirements
- R1: `result_o` is combinational from the operands for each operation code: 0 add, 1 add-with-carry, 2 subtract (a-b), 3 subtract-with-borrow, 4 AND, 5 OR, 6 XOR, and 7, which behaves as XOR.
- R2: Codes 1 and 3 use the stored carry flag (status bit 0) as carry-in or borrow-in. Codes 0 and 2 ignore it.
- R3: Carry (bit 0) takes the unsigned carry out of bit 15 for add codes and the borrow for subtract codes.
- R4: Overflow (bit 11) is set on signed overflow. For add codes this means the operands share a sign and the result sign differs. For subtract codes it means the operand signs differ and the result sign differs from a.
- R5: Auxiliary (bit 4) takes the carry out of bit 3 on add codes and the borrow into bit 3 on subtract codes.
- R6: Zero (bit 6) is set when all 16 result bits are 0. Sign (bit 7) copies result bit 15.
- R7: Parity (bit 2) is set when result bits 7..0 hold an even number of ones. Bits 15..8 have no effect on it.
- R8: Codes 4 to 7 write carry, overflow and auxiliary as 0.
- R9: Condition flags (bits 0, 2, 4, 6, 7, 11) load on the rising clock edge only when `flag_we_i` is 1. Otherwise they hold.
- R10: Control flags are trap (bit 8), interrupt (bit 9) and direction (bit 10). Each is indexed by bits 0, 1, 2 of `ctl_set_i` and `ctl_clr_i`. Set takes priority over clear. With neither input active a control flag holds, and `flag_we_i` has no effect on it.
- R11: After reset the status register reads 16'h0002. Bit 1 always reads 1, and bits 3, 5 and 15..12 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| a_i | input | 16 | First operand |
| b_i | input | 16 | Second operand |
| op_i | input | 3 | Operation code |
| flag_we_i | input | 1 | Load condition flags on this edge |
| ctl_set_i | input | 3 | Set trap / interrupt / direction |
| ctl_clr_i | input | 3 | Clear trap / interrupt / direction |
| result_o | output | 16 | Operation result |
| flags_o | output | 16 | Status register |

## Verification
Directed operand pairs each drive exactly one flag across its boundary:
- 0+0 for zero.
- 0-1 for sign, borrow and nibble borrow.
- 0x000F+1 for the auxiliary carry alone.
- 0x7FFF+1 for signed overflow without carry.
- 0xFFFF+1 for carry with a zero result.

The stored carry is then set before add-with-carry and subtract-with-borrow, so a missing carry-in shows up as a wrong result. Logical results keep the same low byte with different upper bytes, and the reverse, which separates parity over eight bits from parity over sixteen. Seeded random operands, codes, write enables and control pulses then compare every status bit against an integer-arithmetic model. These runs include cycles with the write enable low, to confirm that the condition flags hold.

// File: rtl/alu16_pkg.sv
package alu16_pkg;

  typedef enum logic [2:0] {
    OP_ADD = 3'd0,
    OP_ADC = 3'd1,
    OP_SUB = 3'd2,
    OP_SBB = 3'd3,
    OP_AND = 3'd4,
    OP_OR  = 3'd5,
    OP_XOR = 3'd6,
    OP_RSV = 3'd7
  } alu_op_e;

  localparam int FL_CARRY = 0;
  localparam int FL_PAR   = 2;
  localparam int FL_AUX   = 4;
  localparam int FL_ZERO  = 6;
  localparam int FL_SIGN  = 7;
  localparam int FL_TRAP  = 8;
  localparam int FL_INTR  = 9;
  localparam int FL_DIR   = 10;
  localparam int FL_OVF   = 11;

  localparam int          FLAG_W     = 16;
  localparam int          CTL_N      = 3;
  localparam logic [15:0] FLAG_CONST = 16'h0002;
  localparam logic [15:0] COND_MASK  = 16'h08D5;

  typedef struct packed {
    logic c;
    logic p;
    logic a;
    logic z;
    logic s;
    logic o;
  } cond_t;

endpackage

// File: rtl/alu16_arith.sv
module alu16_arith #(
  parameter int W   = 16,
  parameter int NIB = 4
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         sub_i,
  input  logic         cin_i,
  output logic [W-1:0] res_o,
  output logic         c_o,
  output logic         aux_o,
  output logic         ovf_o
);

  logic [W:0]   full;
  logic [NIB:0] nib;
  logic [W:0]   cin_w;
  logic [NIB:0] cin_n;

  assign cin_w = {{W{1'b0}}, cin_i};
  assign cin_n = {{NIB{1'b0}}, cin_i};

  always_comb begin
    if (sub_i) begin
      full = {1'b0, a_i} - {1'b0, b_i} - cin_w;
      nib  = {1'b0, a_i[NIB-1:0]} - {1'b0, b_i[NIB-1:0]} - cin_n;
    end else begin
      full = {1'b0, a_i} + {1'b0, b_i} + cin_w;
      nib  = {1'b0, a_i[NIB-1:0]} + {1'b0, b_i[NIB-1:0]} + cin_n;
    end
  end

  assign res_o = full[W-1:0];
  assign c_o   = full[W];
  assign aux_o = nib[NIB];
  // subtract flips the sign of b, so the same-sign test inverts
  assign ovf_o = ((a_i[W-1] ^ b_i[W-1]) == sub_i) && (res_o[W-1] != a_i[W-1]);

endmodule

// File: rtl/alu16_logic.sv
module alu16_logic #(
  parameter int W = 16
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [1:0]   sel_i,
  output logic [W-1:0] res_o
);

  always_comb begin
    unique case (sel_i)
      2'd0:    res_o = a_i & b_i;
      2'd1:    res_o = a_i | b_i;
      default: res_o = a_i ^ b_i;
    endcase
  end

endmodule

// File: rtl/alu16_flag_reg.sv
module alu16_flag_reg
  import alu16_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                we_i,
  input  cond_t               cond_i,
  input  logic [CTL_N-1:0]    ctl_set_i,
  input  logic [CTL_N-1:0]    ctl_clr_i,
  output logic [FLAG_W-1:0]   flags_o
);

  cond_t            cond_q;
  logic [CTL_N-1:0] ctl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cond_q <= '0;
    else if (we_i) cond_q <= cond_i;
  end

  for (genvar k = 0; k < CTL_N; k++) begin : g_ctl
    logic bit_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)           bit_q <= 1'b0;
      else if (ctl_set_i[k]) bit_q <= 1'b1;
      else if (ctl_clr_i[k]) bit_q <= 1'b0;
    end
    assign ctl_q[k] = bit_q;

    assert_ctl_set_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ctl_set_i[k] |=> flags_o[FL_TRAP+k]);
    assert_ctl_clr_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ctl_clr_i[k] && !ctl_set_i[k]) |=> !flags_o[FL_TRAP+k]);
    assert_ctl_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!ctl_set_i[k] && !ctl_clr_i[k]) |=> $stable(flags_o[FL_TRAP+k]));
  end

  always_comb begin
    flags_o           = FLAG_CONST;
    flags_o[FL_CARRY] = cond_q.c;
    flags_o[FL_PAR]   = cond_q.p;
    flags_o[FL_AUX]   = cond_q.a;
    flags_o[FL_ZERO]  = cond_q.z;
    flags_o[FL_SIGN]  = cond_q.s;
    flags_o[FL_OVF]   = cond_q.o;
    flags_o[FL_TRAP]  = ctl_q[0];
    flags_o[FL_INTR]  = ctl_q[1];
    flags_o[FL_DIR]   = ctl_q[2];
  end

  assert_cond_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(flags_o & COND_MASK));

endmodule

// File: rtl/alu16_flags.sv
module alu16_flags
  import alu16_pkg::*;
#(
  parameter int WIDTH = 16,
  parameter int PAR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [WIDTH-1:0]  a_i,
  input  logic [WIDTH-1:0]  b_i,
  input  logic [2:0]        op_i,
  input  logic              flag_we_i,
  input  logic [CTL_N-1:0]  ctl_set_i,
  input  logic [CTL_N-1:0]  ctl_clr_i,
  output logic [WIDTH-1:0]  result_o,
  output logic [FLAG_W-1:0] flags_o
);

  alu_op_e          op;
  logic             is_logic;
  logic             is_sub;
  logic             use_cin;
  logic [WIDTH-1:0] arith_res;
  logic [WIDTH-1:0] logic_res;
  logic             arith_c;
  logic             arith_aux;
  logic             arith_ovf;
  cond_t            cond;

  assign op       = alu_op_e'(op_i);
  assign is_logic = op_i[2];
  assign is_sub   = (op == OP_SUB) || (op == OP_SBB);
  assign use_cin  = (op == OP_ADC) || (op == OP_SBB);

  alu16_arith #(.W(WIDTH), .NIB(4)) i_arith (
    .a_i   (a_i),
    .b_i   (b_i),
    .sub_i (is_sub),
    .cin_i (use_cin & flags_o[FL_CARRY]),
    .res_o (arith_res),
    .c_o   (arith_c),
    .aux_o (arith_aux),
    .ovf_o (arith_ovf)
  );

  alu16_logic #(.W(WIDTH)) i_logic (
    .a_i   (a_i),
    .b_i   (b_i),
    .sel_i (op_i[1:0]),
    .res_o (logic_res)
  );

  assign result_o = is_logic ? logic_res : arith_res;

  always_comb begin
    cond.c = !is_logic && arith_c;
    cond.o = !is_logic && arith_ovf;
    cond.a = !is_logic && arith_aux;
    cond.z = (result_o == '0);
    cond.s = result_o[WIDTH-1];
    cond.p = ~^result_o[PAR_W-1:0];
  end

  alu16_flag_reg i_flag_reg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (flag_we_i),
    .cond_i    (cond),
    .ctl_set_i (ctl_set_i),
    .ctl_clr_i (ctl_clr_i),
    .flags_o   (flags_o)
  );

  assert_zero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_we_i |=> flags_o[FL_ZERO] == ($past(result_o) == '0));
  assert_sign_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_we_i |=> flags_o[FL_SIGN] == $past(result_o[WIDTH-1]));
  assert_parity_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_we_i |=> flags_o[FL_PAR] == ~^$past(result_o[PAR_W-1:0]));
  assert_logic_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_we_i && op_i[2]) |=> !flags_o[FL_CARRY] && !flags_o[FL_OVF] && !flags_o[FL_AUX]);
  assert_no_ctl_from_we_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_set_i == '0 && ctl_clr_i == '0) |=> $stable(flags_o[FL_DIR:FL_TRAP]));

endmodule

// File: tb/test_alu16_flags.sv
module test_alu16_flags;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] a = '0, b = '0;
  logic [2:0]  op = '0;
  logic        we = 1'b0;
  logic [2:0]  set = '0, clr = '0;
  logic [15:0] result, flags;
  logic [15:0] exp_fl = 16'h0002;
  int          checks = 0, errors = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  alu16_flags i_alu16_flags (
    .clk_i(clk), .rst_ni(rst_n), .a_i(a), .b_i(b), .op_i(op), .flag_we_i(we),
    .ctl_set_i(set), .ctl_clr_i(clr), .result_o(result), .flags_o(flags)
  );

  task automatic chk(input logic [15:0] act, input logic [15:0] expv, input string tag);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h (a=%h b=%h op=%0d)", tag, act, expv, a, b, op);
    end
  endtask

  // integer reference: returns result and condition bits at their positions
  task automatic ref_step(input logic [15:0] x, input logic [15:0] y, input logic [2:0] o,
                          input logic cf, output logic [15:0] r, output logic [15:0] cb);
    int ci, s, sx, sy, ss, ln;
    bit c = 0, ov = 0, ax = 0, p;
    ci = (o == 3'd1 || o == 3'd3) ? int'(cf) : 0;
    sx = int'($signed(x)); sy = int'($signed(y));
    case (o)
      3'd0, 3'd1: begin
        s = int'(x) + int'(y) + ci; r = s[15:0]; c = s > 65535;
        ln = int'(x[3:0]) + int'(y[3:0]) + ci; ax = ln > 15;
        ss = sx + sy + ci; ov = ss > 32767 || ss < -32768;
      end
      3'd2, 3'd3: begin
        s = int'(x) - int'(y) - ci; r = s[15:0]; c = s < 0;
        ln = int'(x[3:0]) - int'(y[3:0]) - ci; ax = ln < 0;
        ss = sx - sy - ci; ov = ss > 32767 || ss < -32768;
      end
      3'd4: r = x & y;
      3'd5: r = x | y;
      default: r = x ^ y;
    endcase
    p = ($countones(r[7:0]) % 2) == 0;
    cb = '0;
    cb[0] = c; cb[2] = p; cb[4] = ax; cb[6] = (r == 16'h0); cb[7] = r[15]; cb[11] = ov;
  endtask

  task automatic do_op(input logic [15:0] x, input logic [15:0] y, input logic [2:0] o,
                       input logic w, input logic [2:0] st, input logic [2:0] cl);
    logic [15:0] r, cb;
    bit lg;
    @(negedge clk);
    a = x; b = y; op = o; we = w; set = st; clr = cl;
    #1;
    ref_step(x, y, o, exp_fl[0], r, cb);
    chk(result, r, (o == 3'd1 || o == 3'd3) ? "R2 carry-in result" : "R1 result");
    @(posedge clk); #1;
    if (w) exp_fl = (exp_fl & ~16'h08D5) | cb;
    for (int k = 0; k < 3; k++)
      if (st[k]) exp_fl[8+k] = 1'b1;
      else if (cl[k]) exp_fl[8+k] = 1'b0;
    lg = o[2];
    chk({15'b0, flags[0]},  {15'b0, exp_fl[0]},  lg ? "R8 carry" : "R3 carry");
    chk({15'b0, flags[11]}, {15'b0, exp_fl[11]}, lg ? "R8 overflow" : "R4 overflow");
    chk({15'b0, flags[4]},  {15'b0, exp_fl[4]},  lg ? "R8 aux" : "R5 aux");
    chk(flags & 16'h00C0, exp_fl & 16'h00C0, "R6 zero/sign");
    chk({15'b0, flags[2]},  {15'b0, exp_fl[2]},  "R7 parity");
    if (!w) chk(flags & 16'h08D5, exp_fl & 16'h08D5, "R9 hold without write");
    chk(flags & 16'h0700, exp_fl & 16'h0700, "R10 control flags");
    chk(flags & ~16'h0FD5, 16'h0002, "R11 constant bits");
  endtask

  initial begin
    void'($urandom(32'h5A17));
    repeat (3) @(posedge clk);
    #1; chk(flags, 16'h0002, "R11 reset value");
    @(negedge clk); rst_n = 1'b1;

    do_op(16'h0000, 16'h0000, 3'd0, 1, 3'b000, 3'b000); // zero + parity
    do_op(16'h0000, 16'h0001, 3'd2, 1, 3'b000, 3'b000); // sign, borrow, aux borrow
    do_op(16'h000F, 16'h0001, 3'd0, 1, 3'b000, 3'b000); // aux only
    do_op(16'h7FFF, 16'h0001, 3'd0, 1, 3'b000, 3'b000); // signed overflow
    do_op(16'h8000, 16'h0001, 3'd2, 1, 3'b000, 3'b000); // subtract overflow
    do_op(16'hFFFF, 16'h0001, 3'd0, 1, 3'b000, 3'b000); // carry + zero
    do_op(16'h0001, 16'h0001, 3'd1, 1, 3'b000, 3'b000); // R2: 1+1+1
    do_op(16'h0005, 16'h0001, 3'd0, 0, 3'b000, 3'b000); // R2: add ignores carry, no write
    do_op(16'h0000, 16'h0001, 3'd2, 1, 3'b000, 3'b000); // set borrow
    do_op(16'h0005, 16'h0002, 3'd3, 1, 3'b000, 3'b000); // R2: 5-2-1
    do_op(16'hFF03, 16'hFFFF, 3'd4, 1, 3'b000, 3'b000); // R7 low 03 even
    do_op(16'h0003, 16'h0000, 3'd5, 1, 3'b000, 3'b000); // R7 same low byte, upper 00
    do_op(16'hFF00, 16'h0007, 3'd5, 1, 3'b000, 3'b000); // R7 odd
    do_op(16'h0000, 16'h0000, 3'd0, 0, 3'b000, 3'b000); // R9 no write
    do_op(16'h1234, 16'h1234, 3'd7, 1, 3'b111, 3'b000); // code 7 xor, set all ctl
    do_op(16'hFFFF, 16'h0001, 3'd0, 1, 3'b101, 3'b111); // set beats clear
    do_op(16'h8000, 16'h8000, 3'd0, 0, 3'b000, 3'b011); // clear two
    do_op(16'h1111, 16'h2222, 3'd6, 1, 3'b000, 3'b000);

    for (int i = 0; i < 4000; i++) begin
      logic [2:0] st, cl;
      st = ($urandom_range(0, 7) == 0) ? 3'($urandom) : 3'b000;
      cl = ($urandom_range(0, 7) == 0) ? 3'($urandom) : 3'b000;
      do_op(16'($urandom), 16'($urandom), 3'($urandom),
            $urandom_range(0, 4) != 0, st, cl);
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog R9 actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule